// File: doc/BRIEF.md
# Banked-Register Priority Interrupt Controller

This block arbitrates interrupt requests for a processor that keeps one complete set of sixteen general registers per priority level. Nine levels exist: level 0 is the main program and level 8 is the highest, used by the multiplexor channel. Each level has a request line and a device status bit. A status bit set to HIGH lets that level's request compete; a status bit set to LOW masks it.

On every clock the controller finds the highest-numbered unmasked pending level. If that level is above the level now running, the controller switches the running level to it. The processor uses the running level to select the matching register bank, so a context switch needs no memory traffic. Registers 0 and 1 of the new bank hold the status word, and its register-group field is the `curLevel` output. The level that was preempted is pushed onto an internal nine-entry stack.

A return command pops the stack and restores the preempted level and its bank in one cycle. Requests at or below the running level are not dropped. They stay pending and win later, once the running level has fallen below them.

Top module: `pic_top`

## Requirements
- R1: After reset, `curLevel` is 0, `bankSel` equals 9'b000000001 (only bank 0 selected), `intAck` is 0 and the level stack is empty.
- R2: When the highest unmasked pending level is above `curLevel` and `retCmd` is low, the next clock edge sets `curLevel` to that level, and `bankSel` becomes one-hot with bit `curLevel` set.
- R3: When several unmasked requests are pending, the highest-numbered level is the one granted.
- R4: A request at or below `curLevel` causes no change. It stays eligible, and it is granted once a return lowers `curLevel` below it.
- R5: A request whose `devHigh` bit is 0 (LOW) takes no part in arbitration.
- R6: When `retCmd` is high and the stack is not empty, the next edge restores the most recently preempted level.
- R7: When `retCmd` is high and the stack is empty (`curLevel` is 0), nothing changes.
- R8: When `retCmd` is high, no grant happens in that cycle. A request that is still pending is evaluated against the restored level on the following cycle.
- R9: Each grant raises `intAck` for exactly one cycle, in the same cycle as the level change, with `ackLevel` equal to the new level.
- R10: Nesting works through all eight levels above the main program, and nine successive returns unwind it back to level 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqLevel | input | 9 | Pending request, one bit per priority level |
| devHigh | input | 9 | Device status bit per level: 1 = HIGH (enabled), 0 = LOW (masked) |
| retCmd | input | 1 | Return-from-interrupt command |
| curLevel | output | 4 | Running priority level (register-group field of the status word) |
| bankSel | output | 9 | One-hot register bank select |
| intAck | output | 1 | One-cycle pulse marking a grant |
| ackLevel | output | 4 | Level granted, valid while `intAck` is high |

## Verification
The hardest state to reach is a full eight-deep nesting, because every preemption needs a request strictly above the last one with no return in between. A directed ladder raises one request at a time from level 1 up to level 8. It then issues nine returns, the last of which lands on an empty stack. A return that coincides with a pending higher request is also rare under random stimulus, so it is driven on purpose. A long random phase, with sparse requests, random masking and occasional returns, then exercises mixed nesting depths against a bench model of the level stack.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  localparam int LEVELS = 9;
  localparam int LVL_W  = $clog2(LEVELS);

  typedef logic [LVL_W-1:0] level_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic   push;      // preempt: save running level, switch to newLevel
    logic   pop;       // return: restore top of stack
    level_t newLevel;  // level being granted
  } strobe_t;
endpackage

// File: rtl/pic_ctrl.sv
`timescale 1ns/1ps
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_LEVELS = LEVELS
) (
  input  logic [NUM_LEVELS-1:0] reqLevel,
  input  logic [NUM_LEVELS-1:0] devHigh,
  input  logic                  retCmd,
  input  level_t                curLevel,
  input  logic                  stackEmpty,
  input  logic                  stackFull,
  output strobe_t               strobe
);

  logic [NUM_LEVELS-1:0] eligible;
  level_t                bestLevel;
  logic                  anyReq;

  assign eligible = reqLevel & devHigh;

  // Highest-numbered eligible level wins
  always_comb begin
    bestLevel = '0;
    anyReq    = 1'b0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (eligible[i]) begin
        bestLevel = level_t'(i);
        anyReq    = 1'b1;
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.newLevel = bestLevel;
    if (retCmd) begin
      strobe.pop = !stackEmpty;
    end else if (anyReq && (bestLevel > curLevel) && !stackFull) begin
      strobe.push = 1'b1;
    end
  end

endmodule

// File: rtl/pic_datapath.sv
`timescale 1ns/1ps
module pic_datapath
  import pic_pkg::*;
#(
  parameter int NUM_LEVELS  = LEVELS,
  parameter int STACK_DEPTH = LEVELS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobe,
  output level_t                curLevel,
  output logic [NUM_LEVELS-1:0] bankSel,
  output logic                  intAck,
  output level_t                ackLevel,
  output logic                  stackEmpty,
  output logic                  stackFull
);

  localparam int SP_W = $clog2(STACK_DEPTH + 1);

  level_t          stackMem [STACK_DEPTH];
  logic [SP_W-1:0] sp;
  logic [SP_W-1:0] spMinus1;
  level_t          levelQ;
  logic            ackQ;
  level_t          ackLvlQ;

  assign spMinus1   = sp - 1'b1;
  assign stackEmpty = (sp == '0);
  assign stackFull  = (sp == SP_W'(STACK_DEPTH));

  // Level stack storage, no reset needed
  always_ff @(posedge clk) begin
    if (strobe.push && !strobe.pop) begin
      stackMem[sp] <= levelQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ  <= '0;
      sp      <= '0;
      ackQ    <= 1'b0;
      ackLvlQ <= '0;
    end else begin
      ackQ <= 1'b0;
      if (strobe.pop) begin
        sp     <= spMinus1;
        levelQ <= stackMem[spMinus1];
      end else if (strobe.push) begin
        sp      <= sp + 1'b1;
        levelQ  <= strobe.newLevel;
        ackQ    <= 1'b1;
        ackLvlQ <= strobe.newLevel;
      end
    end
  end

  always_comb begin
    bankSel         = '0;
    bankSel[levelQ] = 1'b1;
  end

  assign curLevel = levelQ;
  assign intAck   = ackQ;
  assign ackLevel = ackLvlQ;

endmodule

// File: rtl/pic_top.sv
`timescale 1ns/1ps
module pic_top
  import pic_pkg::*;
#(
  parameter int NUM_LEVELS = LEVELS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] reqLevel,
  input  logic [NUM_LEVELS-1:0] devHigh,
  input  logic                  retCmd,
  output logic [LVL_W-1:0]      curLevel,
  output logic [NUM_LEVELS-1:0] bankSel,
  output logic                  intAck,
  output logic [LVL_W-1:0]      ackLevel
);

  strobe_t strobe;
  logic    stackEmpty;
  logic    stackFull;

  pic_ctrl #(.NUM_LEVELS(NUM_LEVELS)) u_ctrl (
    .reqLevel  (reqLevel),
    .devHigh   (devHigh),
    .retCmd    (retCmd),
    .curLevel  (curLevel),
    .stackEmpty(stackEmpty),
    .stackFull (stackFull),
    .strobe    (strobe)
  );

  pic_datapath #(.NUM_LEVELS(NUM_LEVELS), .STACK_DEPTH(NUM_LEVELS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .curLevel  (curLevel),
    .bankSel   (bankSel),
    .intAck    (intAck),
    .ackLevel  (ackLevel),
    .stackEmpty(stackEmpty),
    .stackFull (stackFull)
  );

endmodule

// File: rtl/pic_checker.sv
`timescale 1ns/1ps
module pic_checker
  import pic_pkg::*;
#(
  parameter int NUM_LEVELS = LEVELS
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_LEVELS-1:0] reqLevel,
  input logic [NUM_LEVELS-1:0] devHigh,
  input logic                  retCmd,
  input logic [LVL_W-1:0]      curLevel,
  input logic [NUM_LEVELS-1:0] bankSel,
  input logic                  intAck,
  input logic [LVL_W-1:0]      ackLevel
);

  // R2: bank select is one-hot and matches the running level
  assert_bank_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(bankSel) == 1) && bankSel[curLevel]);

  // R9: an ack coincides with a rise in level to the acked level
  assert_ack_raises_R9: assert property (@(posedge clk) disable iff (!rstN)
    !retCmd ##1 intAck |-> (curLevel == ackLevel) && (curLevel > $past(curLevel)));

  // R5 / R4: nothing eligible above the running level keeps the level
  assert_no_grant_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!retCmd && ((((reqLevel & devHigh) >> curLevel) >> 1) == '0))
      |=> (!intAck && (curLevel == $past(curLevel))));

  // R6: a return from a nested level lowers the level
  assert_ret_lowers_R6: assert property (@(posedge clk) disable iff (!rstN)
    (retCmd && (curLevel != '0)) |=> (curLevel < $past(curLevel)));

  // R7: a return at the main program changes nothing
  assert_ret_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    (retCmd && (curLevel == '0)) |=> (curLevel == '0));

  // R8: a return blocks a grant in the same cycle
  assert_ret_no_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    retCmd |=> !intAck);

endmodule

bind pic_top pic_checker #(.NUM_LEVELS(NUM_LEVELS)) u_pic_checker (
  .clk     (clk),
  .rstN    (rstN),
  .reqLevel(reqLevel),
  .devHigh (devHigh),
  .retCmd  (retCmd),
  .curLevel(curLevel),
  .bankSel (bankSel),
  .intAck  (intAck),
  .ackLevel(ackLevel)
);

// File: tb/test_pic_top.sv
`timescale 1ns/1ps
module test_pic_top;
  localparam int NL = 9;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NL-1:0] reqLevel = '0;
  logic [NL-1:0] devHigh = '1;
  logic          retCmd = 1'b0;
  logic [3:0]    curLevel;
  logic [NL-1:0] bankSel;
  logic          intAck;
  logic [3:0]    ackLevel;

  int checkCount = 0;
  int failCount  = 0;
  bit done       = 1'b0;

  // Bench model of the running level and stack
  int mLevel = 0;
  int mSp    = 0;
  int mStack [NL];
  bit mAck   = 1'b0;
  int mAckLvl = 0;

  always #4 clk = ~clk;

  pic_top i_pic_top (
    .clk(clk), .rstN(rstN), .reqLevel(reqLevel), .devHigh(devHigh),
    .retCmd(retCmd), .curLevel(curLevel), .bankSel(bankSel),
    .intAck(intAck), .ackLevel(ackLevel)
  );

  function automatic logic [NL-1:0] oneHot(int lvl);
    logic [NL-1:0] v = '0;
    v[lvl] = 1'b1;
    return v;
  endfunction

  function automatic int highestEligible(logic [NL-1:0] r, logic [NL-1:0] h);
    int best = -1;
    for (int i = 0; i < NL; i++) if (r[i] && h[i]) best = i;
    return best;
  endfunction

  task automatic modelStep(logic [NL-1:0] r, logic [NL-1:0] h, logic ret);
    int best = highestEligible(r, h);
    mAck = 1'b0;
    if (ret) begin
      if (mSp > 0) begin
        mSp--;
        mLevel = mStack[mSp];
      end
    end else if (best > mLevel && mSp < NL) begin
      mStack[mSp] = mLevel;
      mSp++;
      mLevel = best;
      mAck = 1'b1;
      mAckLvl = best;
    end
  endtask

  task automatic check(string tag, string what, int act, int exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic checkOutputs(string tag);
    check(tag, "curLevel", int'(curLevel), mLevel);
    check(tag, "bankSel", int'(bankSel), int'(oneHot(mLevel)));
    check(tag, "intAck", int'(intAck), int'(mAck));
    if (mAck) check(tag, "ackLevel", int'(ackLevel), mAckLvl);
  endtask

  // Drive at negedge, let one posedge pass, check at next negedge
  task automatic step(logic [NL-1:0] r, logic [NL-1:0] h, logic ret, string tag);
    reqLevel = r;
    devHigh  = h;
    retCmd   = ret;
    modelStep(r, h, ret);
    @(negedge clk);
    checkOutputs(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [NL-1:0] allHigh = '1;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkOutputs("R1");

    step(9'b000000100, allHigh, 1'b0, "R2");          // grant level 2
    step(9'b001010010, allHigh, 1'b0, "R3");          // 6 wins over 1,4
    step(9'b000001000, allHigh, 1'b0, "R4");          // 3 below 6: held
    step(9'b100001000, 9'b011111111, 1'b0, "R5");     // 8 masked LOW
    step(9'b000001000, allHigh, 1'b1, "R6");          // return to 2
    step(9'b000001000, allHigh, 1'b0, "R4");          // pending 3 now wins
    step(9'b100000000, allHigh, 1'b1, "R8");          // return wins over 8
    check("R8", "curLevel", int'(curLevel), 2);
    step(9'b100000000, allHigh, 1'b0, "R8");          // 8 granted next cycle
    step(9'b000000000, allHigh, 1'b1, "R6");
    step(9'b000000000, allHigh, 1'b1, "R6");
    step(9'b000000000, allHigh, 1'b1, "R7");          // empty stack
    check("R7", "curLevel", int'(curLevel), 0);
    step(9'b000000000, allHigh, 1'b1, "R7");

    // R10: ladder 1..8 then nine returns
    for (int l = 1; l < NL; l++) step(oneHot(l), allHigh, 1'b0, "R10");
    check("R10", "curLevel", int'(curLevel), 8);
    for (int k = 0; k < NL; k++) step('0, allHigh, 1'b1, "R10");
    check("R10", "curLevel", int'(curLevel), 0);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      logic [NL-1:0] r = NL'($urandom) & NL'($urandom) & NL'($urandom);
      logic [NL-1:0] h = NL'($urandom) | NL'($urandom);
      logic ret = ($urandom % 4) == 0;
      step(r, h, ret, "R2");
    end

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule